// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. Each accepted request brings an operation code, the current accumulator, one 8-bit operand and the current flag byte. One clock later the block presents the new accumulator value and the new flag byte. A separate 16-bit path adds two register-pair values for the wide add. The surrounding core handles instruction fetch, decode, memory, stack and interrupts, and writes the results back.

The flag byte keeps a fixed layout: sign in bit 7, zero in bit 6, auxiliary carry in bit 4, parity in bit 2 and carry in bit 0. Bit 1 is always 1, and bits 5 and 3 are always 0. The auxiliary carry follows per-operation rules: AND looks at bit 3 of the OR of its inputs, subtraction reports an inverted half-borrow, and increment and decrement test the nibble of the result.

Top module: `acc_alu`

## Requirements
- R1: Every flag byte the block outputs has sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0, with bit 1 forced to 1 and bits 5 and 3 forced to 0, even when the incoming flag byte has other values in those bits.
- R2: Op 0 (add) and op 1 (add with carry-in = incoming carry) form a 9-bit sum of accumulator and operand. The result is the low 8 bits, carry is sum bit 8, and auxiliary carry is the carry out of bit 3.
- R3: Op 2 (subtract), op 3 (subtract with borrow-in = incoming carry) and op 4 (compare) form a 9-bit difference. Carry is the borrow from bit 8. Auxiliary carry is 1 when the low nibble produces no borrow. Compare sets all flags this way but outputs the accumulator unchanged.
- R4: Op 5 (AND) sets auxiliary carry to bit 3 of (accumulator OR operand) and clears carry. Op 6 (OR) and op 7 (XOR) clear both auxiliary carry and carry.
- R5: Op 8 outputs operand+1 and op 9 outputs operand-1, both modulo 256, with carry unchanged. Increment sets auxiliary carry only when the result's low nibble is 0. Decrement sets it unless that nibble is 0xF.
- R6: Op 10 rotates the accumulator left and op 11 rotates it right; in both, the bit that leaves goes to carry and into the vacated bit. Op 12 rotates left and op 13 rotates right through carry: the old carry fills the vacated bit and the bit that leaves becomes carry. No other flag changes.
- R7: Op 14 inverts the accumulator and changes no flag. Op 15 sets carry to 1 and op 16 inverts carry; both keep the accumulator and all other flags.
- R8: Op 17 (decimal adjust) adds 0x06 when auxiliary carry is set or the low nibble is above 9. It adds 0x60 when carry is set, the high nibble is above 9, or the high nibble is at least 9 while the low nibble is above 9. Auxiliary carry and the S/Z/P flags come from this add. Carry becomes 1 after a 0x60 correction and otherwise keeps its prior value.
- R9: Op 18 outputs the sum of the two 16-bit pair inputs modulo 65536 and sets carry from bit 16, with no other flag changed and the accumulator unchanged. For every other op the pair output equals the first pair input.
- R10: Sign equals result bit 7, zero is 1 when the 8-bit result is 0, and parity is 1 when the result has an even number of one bits. These flags are updated by ops 0 to 9 and 17 (for compare, from the difference) and kept by all other ops.
- R11: After a synchronous active-low reset, out_valid is 0, the result and pair outputs are 0, and the flag output is 0x02.
- R12: A request accepted with in_valid high appears on the outputs one clock later with out_valid high. While in_valid is low, out_valid is 0 and the outputs hold their values.
- R13: Op codes 19 to 31 output the accumulator and the incoming flags unchanged, apart from the reserved-bit normalisation of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request is presented this cycle |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Second operand / increment-decrement source |
| flags_i | input | 8 | Current flag byte |
| pair_a_i | input | 16 | Wide accumulator pair |
| pair_b_i | input | 16 | Wide addend pair |
| out_valid | output | 1 | Results below belong to last accepted request |
| res_o | output | 8 | New accumulator / increment-decrement result |
| flags_o | output | 8 | New flag byte |
| pair_o | output | 16 | New wide accumulator pair |

## Verification
The assertions assume that in_valid is held low while reset is asserted. They also assume that every value on op_i, acc_i, flags_i and the pair inputs is known whenever in_valid is high, since the one-cycle checks compare the registered outputs with these inputs as sampled at the previous edge. The stimulus drives all inputs at the falling edge and keeps in_valid low through reset. It covers every accumulator value against a strided set of operands, every incoming carry and auxiliary-carry combination, and random values in the unused flag bits. Unused op codes and idle cycles are also exercised, and every result is compared each cycle against a behavioural model in the bench.

// File: rtl/acc_alu_pkg.sv
// Package: shared operation codes, flag bit positions and helpers for the
// accumulator ALU. Assumes an 8-bit data path with a fixed flag layout.
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 5;

    // Flag bit positions; the core decodes these, so they are fixed.
    localparam int FLG_S  = 7;
    localparam int FLG_Z  = 6;
    localparam int FLG_AC = 4;
    localparam int FLG_P  = 2;
    localparam int FLG_CY = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBB  = 5'd3,
        OP_CMP  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_INC  = 5'd8,
        OP_DEC  = 5'd9,
        OP_RLC  = 5'd10,
        OP_RRC  = 5'd11,
        OP_RAL  = 5'd12,
        OP_RAR  = 5'd13,
        OP_CMA  = 5'd14,
        OP_STC  = 5'd15,
        OP_CMC  = 5'd16,
        OP_DAA  = 5'd17,
        OP_PAIR = 5'd18
    } alu_op_e;

    // Sign, zero and parity for an 8-bit result, placed in their flag bits.
    function automatic logic [7:0] szp_bits(input logic [7:0] v);
        logic [7:0] f;
        f         = '0;
        f[FLG_S]  = v[7];
        f[FLG_Z]  = (v == 8'h00);
        f[FLG_P]  = ~^v;
        return f;
    endfunction

    // Force the reserved flag bits to their fixed values.
    function automatic logic [7:0] fix_reserved(input logic [7:0] f);
        logic [7:0] r;
        r    = f;
        r[1] = 1'b1;
        r[3] = 1'b0;
        r[5] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
// Module: 8-bit adder/subtractor with carry-in, producing carry (or borrow)
// and the auxiliary flag. For subtraction the auxiliary output is the
// inverse of the low-nibble borrow. Purely combinational.
module acc_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cy_o,
    output logic         ac_o
);
    localparam int NIB = W / 2;

    logic [W:0]   full;
    logic [NIB:0] half;

    // Full-width and low-nibble arithmetic for both directions.
    always_comb begin
        if (sub_i) begin
            full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
            half = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - {{NIB{1'b0}}, cin_i};
            ac_o = ~half[NIB];
        end else begin
            full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
            half = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
            ac_o = half[NIB];
        end
        sum_o = full[W-1:0];
        cy_o  = full[W];
    end

endmodule

// File: rtl/acc_alu_bitops.sv
// Module: logical, rotate, complement and increment/decrement results with
// their carry and auxiliary outputs. Assumes op codes from acc_alu_pkg;
// ops it does not own return the accumulator and the incoming carry.
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cy_i,
    output logic [W-1:0] res_o,
    output logic         cy_o,
    output logic         ac_o
);
    localparam int NIB = W / 2;

    logic [W-1:0] or_v;
    logic [W-1:0] inc_v;
    logic [W-1:0] dec_v;

    assign or_v  = a_i | b_i;
    assign inc_v = b_i + {{(W-1){1'b0}}, 1'b1};
    assign dec_v = b_i - {{(W-1){1'b0}}, 1'b1};

    // Select the result and the two carry-type outputs per operation.
    always_comb begin
        res_o = a_i;
        cy_o  = cy_i;
        ac_o  = 1'b0;
        unique case (op_i)
            OP_AND: begin res_o = a_i & b_i; cy_o = 1'b0; ac_o = or_v[NIB-1]; end
            OP_OR:  begin res_o = or_v;      cy_o = 1'b0; end
            OP_XOR: begin res_o = a_i ^ b_i; cy_o = 1'b0; end
            OP_INC: begin res_o = inc_v; ac_o = (inc_v[NIB-1:0] == '0); end
            OP_DEC: begin res_o = dec_v; ac_o = (dec_v[NIB-1:0] != '1); end
            OP_RLC: begin res_o = {a_i[W-2:0], a_i[W-1]}; cy_o = a_i[W-1]; end
            OP_RRC: begin res_o = {a_i[0], a_i[W-1:1]};   cy_o = a_i[0];   end
            OP_RAL: begin res_o = {a_i[W-2:0], cy_i};     cy_o = a_i[W-1]; end
            OP_RAR: begin res_o = {cy_i, a_i[W-1:1]};     cy_o = a_i[0];   end
            OP_CMA: begin res_o = ~a_i; end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_alu_decadj.sv
// Module: decimal-adjust correction select. Produces the value to add to
// the accumulator and whether carry must be forced. Combinational.
module acc_alu_decadj #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         ac_i,
    input  logic         cy_i,
    output logic [W-1:0] corr_o,
    output logic         cy_force_o
);
    localparam int NIB = W / 2;

    logic [NIB-1:0] lo;
    logic [NIB-1:0] hi;
    logic           lo_fix;
    logic           hi_fix;

    assign lo = a_i[NIB-1:0];
    assign hi = a_i[W-1:NIB];

    // Decide which nibble corrections apply.
    always_comb begin
        lo_fix     = ac_i || (lo > NIB'(9));
        hi_fix     = cy_i || (hi > NIB'(9)) || ((hi >= NIB'(9)) && (lo > NIB'(9)));
        corr_o     = {(hi_fix ? NIB'(6) : NIB'(0)), (lo_fix ? NIB'(6) : NIB'(0))};
        cy_force_o = hi_fix;
    end

endmodule

// File: rtl/acc_alu.sv
// Module: accumulator ALU top. Combines the arithmetic, bit-operation and
// decimal-adjust units, builds the flag byte and registers the results one
// cycle after each accepted request. Assumes in_valid is low during reset.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int PW = 2 * DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [4:0]    op_i,
    input  logic [W-1:0]  acc_i,
    input  logic [W-1:0]  opnd_i,
    input  logic [7:0]    flags_i,
    input  logic [PW-1:0] pair_a_i,
    input  logic [PW-1:0] pair_b_i,
    output logic          out_valid,
    output logic [W-1:0]  res_o,
    output logic [7:0]    flags_o,
    output logic [PW-1:0] pair_o
);
    alu_op_e       op;
    logic          cy_in;
    logic          ac_in;

    logic [W-1:0]  as_a, as_b, as_sum;
    logic          as_cin, as_sub, as_cy, as_ac;

    logic [W-1:0]  bo_res;
    logic          bo_cy, bo_ac;

    logic [W-1:0]  da_corr;
    logic          da_force;

    logic [PW:0]   pair_sum;

    logic [W-1:0]  res_d;
    logic [7:0]    flags_d;
    logic [PW-1:0] pair_d;

    assign op       = alu_op_e'(op_i);
    assign cy_in    = flags_i[FLG_CY];
    assign ac_in    = flags_i[FLG_AC];
    assign pair_sum = {1'b0, pair_a_i} + {1'b0, pair_b_i};

    acc_alu_addsub #(.W(W)) u_addsub (
        .a_i   (as_a),
        .b_i   (as_b),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .sum_o (as_sum),
        .cy_o  (as_cy),
        .ac_o  (as_ac)
    );

    acc_alu_bitops #(.W(W)) u_bitops (
        .op_i  (op),
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .cy_i  (cy_in),
        .res_o (bo_res),
        .cy_o  (bo_cy),
        .ac_o  (bo_ac)
    );

    acc_alu_decadj #(.W(W)) u_decadj (
        .a_i        (acc_i),
        .ac_i       (ac_in),
        .cy_i       (cy_in),
        .corr_o     (da_corr),
        .cy_force_o (da_force)
    );

    // Steer the shared adder: operand or decimal correction, carry-in, direction.
    always_comb begin
        as_a   = acc_i;
        as_b   = opnd_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC:         as_cin = cy_in;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBB: begin   as_sub = 1'b1; as_cin = cy_in; end
            OP_DAA:         as_b   = da_corr;
            default: ;
        endcase
    end

    // Build next result, flag byte and pair value for the selected op.
    always_comb begin
        res_d   = acc_i;
        flags_d = flags_i;
        pair_d  = pair_a_i;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
                res_d            = (op == OP_CMP) ? acc_i : as_sum;
                flags_d          = szp_bits(as_sum);
                flags_d[FLG_AC]  = as_ac;
                flags_d[FLG_CY]  = as_cy;
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
                res_d            = bo_res;
                flags_d          = szp_bits(bo_res);
                flags_d[FLG_AC]  = bo_ac;
                flags_d[FLG_CY]  = bo_cy;
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR, OP_CMA: begin
                res_d            = bo_res;
                flags_d[FLG_CY]  = bo_cy;
            end
            OP_STC: flags_d[FLG_CY] = 1'b1;
            OP_CMC: flags_d[FLG_CY] = ~cy_in;
            OP_DAA: begin
                res_d            = as_sum;
                flags_d          = szp_bits(as_sum);
                flags_d[FLG_AC]  = as_ac;
                flags_d[FLG_CY]  = cy_in | da_force;
            end
            OP_PAIR: begin
                pair_d           = pair_sum[PW-1:0];
                flags_d[FLG_CY]  = pair_sum[PW];
            end
            default: ;
        endcase
        flags_d = fix_reserved(flags_d);
    end

    // Output registers: capture on accepted request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_o     <= '0;
            flags_o   <= 8'h02;
            pair_o    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_o   <= res_d;
                flags_o <= flags_d;
                pair_o  <= pair_d;
            end
        end
    end

    AST_RESERVED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (flags_o[1] && !flags_o[3] && !flags_o[5])); // R1

    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_i) == 5'd4) |-> res_o == $past(acc_i)); // R3

    AST_LOGIC_CLEARS_CY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_i) >= 5'd5 && $past(op_i) <= 5'd7)
        |-> !flags_o[FLG_CY]); // R4

    AST_INCDEC_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(op_i) == 5'd8 || $past(op_i) == 5'd9))
        |-> flags_o[FLG_CY] == $past(flags_i[FLG_CY])); // R5

    AST_CMA_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_i) == 5'd14)
        |-> (flags_o[7:6] == $past(flags_i[7:6]) && flags_o[4] == $past(flags_i[4])
             && flags_o[2] == $past(flags_i[2]) && flags_o[0] == $past(flags_i[0]))); // R7

    AST_PAIR_ONLY_CY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_i) == 5'd18)
        |-> (flags_o[7:6] == $past(flags_i[7:6]) && flags_o[4] == $past(flags_i[4])
             && flags_o[2] == $past(flags_i[2]) && res_o == $past(acc_i))); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid))
        |-> (!out_valid && $stable(res_o) && $stable(flags_o) && $stable(pair_o))); // R12

endmodule

// File: tb/acc_alu_bench.sv
// Bench: drives requests at the falling edge, checks each registered result
// one cycle later against a behavioural model written with integers.
module acc_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_i = '0;
    logic [7:0]  acc_i = '0;
    logic [7:0]  opnd_i = '0;
    logic [7:0]  flags_i = '0;
    logic [15:0] pair_a_i = '0;
    logic [15:0] pair_b_i = '0;
    logic        out_valid;
    logic [7:0]  res_o;
    logic [7:0]  flags_o;
    logic [15:0] pair_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    acc_alu u_acc_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .flags_i(flags_i),
        .pair_a_i(pair_a_i), .pair_b_i(pair_b_i),
        .out_valid(out_valid), .res_o(res_o), .flags_o(flags_o), .pair_o(pair_o)
    );

    function automatic int parity_even(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return (n % 2 == 0) ? 1 : 0;
    endfunction

    // Behavioural model of one operation.
    function automatic void model(input int op, input int a, input int b, input int f,
                                  input int pa, input int pb,
                                  output int r, output int fo, output int po);
        int cy, ac, s, v, cin, add, lo, hi, szp_upd;
        cy = f & 1; ac = (f >> 4) & 1; r = a; po = pa; v = a; szp_upd = 0;
        case (op)
            0, 1: begin
                cin = (op == 1) ? cy : 0;
                s = a + b + cin; ac = (((a & 15) + (b & 15) + cin) > 15) ? 1 : 0;
                cy = (s > 255) ? 1 : 0; v = s & 255; r = v; szp_upd = 1;
            end
            2, 3, 4: begin
                cin = (op == 3) ? cy : 0;
                s = a - b - cin; ac = (((a & 15) - (b & 15) - cin) < 0) ? 0 : 1;
                cy = (s < 0) ? 1 : 0; v = s & 255; r = (op == 4) ? a : v; szp_upd = 1;
            end
            5: begin v = a & b; ac = ((a | b) >> 3) & 1; cy = 0; r = v; szp_upd = 1; end
            6: begin v = a | b; ac = 0; cy = 0; r = v; szp_upd = 1; end
            7: begin v = a ^ b; ac = 0; cy = 0; r = v; szp_upd = 1; end
            8: begin v = (b + 1) & 255; ac = ((v & 15) == 0) ? 1 : 0; r = v; szp_upd = 1; end
            9: begin v = (b + 255) & 255; ac = ((v & 15) != 15) ? 1 : 0; r = v; szp_upd = 1; end
            10: begin cy = a >> 7; r = ((a << 1) | cy) & 255; end
            11: begin cy = a & 1;  r = (a >> 1) | (cy << 7); end
            12: begin r = ((a << 1) | cy) & 255; cy = a >> 7; end
            13: begin r = (a >> 1) | (cy << 7); cy = a & 1; end
            14: r = a ^ 255;
            15: cy = 1;
            16: cy = 1 - cy;
            17: begin
                lo = a & 15; hi = a >> 4; add = 0;
                if (ac == 1 || lo > 9) add = 6;
                if (cy == 1 || hi > 9 || (hi >= 9 && lo > 9)) begin add += 96; cy = 1; end
                ac = (((a & 15) + (add & 15)) > 15) ? 1 : 0;
                v = (a + add) & 255; r = v; szp_upd = 1;
            end
            18: begin s = pa + pb; cy = (s >> 16) & 1; po = s & 65535; end
            default: ;
        endcase
        fo = f & 8'hC4;
        if (szp_upd == 1) begin
            fo = 0;
            if (v >= 128) fo |= 128;
            if (v == 0) fo |= 64;
            if (parity_even(v) == 1) fo |= 4;
        end
        fo |= (ac << 4) | cy | 2;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One request: drive at falling edge, check at the next falling edge.
    task automatic run_op(input string tag, input int op, input int a, input int b,
                          input int f, input int pa, input int pb);
        int er, ef, ep;
        model(op, a, b, f, pa, pb, er, ef, ep);
        op_i = op[4:0]; acc_i = a[7:0]; opnd_i = b[7:0]; flags_i = f[7:0];
        pair_a_i = pa[15:0]; pair_b_i = pb[15:0]; in_valid = 1'b1;
        @(negedge clk);
        checks++;
        if (!out_valid || res_o != er[7:0] || flags_o != ef[7:0] || pair_o != ep[15:0]) begin
            fails++;
            $display("FAIL %s op %0d a %0h b %0h f %0h: actual v%0b r%0h f%0h p%0h expected v1 r%0h f%0h p%0h",
                     tag, op, a, b, f, out_valid, res_o, flags_o, pair_o, er, ef, ep);
        end
    endtask

    function automatic int mk_flags(input int c, input int h);
        return ($urandom & 8'hEE) | (h << 4) | c;
    endfunction

    // Watchdog: an expired run counts as one failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11", "out_valid", out_valid, 0);
        check("R11", "res", res_o, 0);
        check("R11", "flags", flags_o, 8'h02);
        check("R11", "pair", pair_o, 0);

        // R2, R3, R10: arithmetic against a strided operand set
        for (int op = 0; op <= 4; op++)
            for (int a = 0; a < 256; a++)
                for (int j = 0; j < 16; j++)
                    for (int c = 0; c < 2; c++)
                        run_op(op < 2 ? "R2" : "R3", op, a, j * 16 + ((a + j) & 15),
                               mk_flags(c, j & 1), 0, 0);
        // R4, R10: logic ops
        for (int op = 5; op <= 7; op++)
            for (int a = 0; a < 256; a++)
                for (int j = 0; j < 16; j++)
                    run_op("R4", op, a, j * 17 ^ (a >> 4), mk_flags(j & 1, (j >> 1) & 1), 0, 0);
        // R5: increment / decrement of the operand
        for (int op = 8; op <= 9; op++)
            for (int b = 0; b < 256; b++)
                for (int fl = 0; fl < 4; fl++)
                    run_op("R5", op, b ^ 8'h5A, b, mk_flags(fl & 1, fl >> 1), 0, 0);
        // R6: rotates
        for (int op = 10; op <= 13; op++)
            for (int a = 0; a < 256; a++)
                for (int c = 0; c < 2; c++)
                    run_op("R6", op, a, 0, mk_flags(c, a & 1), 0, 0);
        // R7: complement accumulator, set carry, complement carry
        for (int op = 14; op <= 16; op++)
            for (int a = 0; a < 256; a++)
                for (int c = 0; c < 2; c++)
                    run_op("R7", op, a, 0, mk_flags(c, (a >> 3) & 1), 0, 0);
        // R8: decimal adjust over all inputs and carry/aux combinations
        for (int a = 0; a < 256; a++)
            for (int fl = 0; fl < 4; fl++)
                run_op("R8", 17, a, 0, mk_flags(fl & 1, fl >> 1), 0, 0);
        // R9: wide pair add, including the wrap corner
        run_op("R9", 18, 8'h33, 0, mk_flags(0, 1), 16'hFFFF, 16'h0001);
        run_op("R9", 18, 8'h33, 0, mk_flags(1, 0), 16'h0000, 16'h0000);
        for (int i = 0; i < 2000; i++)
            run_op("R9", 18, i & 255, 0, mk_flags(i & 1, (i >> 1) & 1),
                   int'($urandom & 16'hFFFF), int'($urandom & 16'hFFFF));
        // R1, R13: unused codes pass through with reserved bits fixed
        for (int op = 19; op < 32; op++)
            run_op("R13", op, op * 7, op, 8'hFF, 16'h1234, 16'h4321);
        run_op("R1", 0, 8'h01, 8'h01, 8'h28, 0, 0);

        // R12: idle cycles keep the outputs and drop out_valid
        in_valid = 1'b0;
        @(negedge clk);
        check("R12", "out_valid idle", out_valid, 0);
        check("R12", "res hold", res_o, 8'h02);
        repeat (2) @(negedge clk);
        check("R12", "flags hold", flags_o, 8'h02);
        check("R12", "pair hold", pair_o, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule